// File: doc/BRIEF.md
# Indexed Register Port Front End

This block is the byte-wide I/O front end of a legacy-style display controller. A host drives a short address, a data byte and one-cycle read or write strobes. Six register groups use an index/data pair: the host writes a register number to the group's index port, then reads or writes the chosen register through the data port at the next address up. Each group keeps its own index and its own register array, so switching between groups never disturbs another group's selection.

The attribute group has only one write address. A toggle inside the block decides whether a write at that address is an index or a data byte. Reading the second status register puts the toggle back into the index state, which gives software a known starting point. Bit 5 of the attribute index byte drives the video-enable output. The byte-wide miscellaneous output register is write-only and is driven out of the block. The display meaning of the stored values is handled elsewhere.

Top module: `irp_regfront`

## Requirements
- R1: Each group's index port stores the written byte and returns it on read. The index ports are sequencer 0x3C4, graphics 0x3CE, CRT 0x3D4, extended 0x3D6, flat panel 0x3D0 and multimedia 0x3D2.
- R2: A write to a group's data port (index port + 1) stores the byte in the register selected by that group's current index. A read of the data port returns that register.
- R3: Group sizes are 8 (sequencer), 9 (graphics), 128 (CRT), 256 (extended), 128 (flat panel) and 64 (multimedia). A data-port write while the index is at or above the size has no effect, and a data-port read in that state returns 0x00.
- R4: At 0x3C0, the first write after synchronisation loads the attribute index, the next write stores data into the indexed attribute register, and later writes keep alternating in the same way.
- R5: A read at 0x3DA returns 0x00 and forces the attribute toggle to the index state.
- R6: An attribute index write sets video_en to bit 5 of the byte. A read of 0x3C0 returns {2'b00, video_en, index[4:0]}.
- R7: There are 21 attribute registers (indices 0x00–0x14). A read of 0x3C1 returns the selected register. For indices 0x15–0x1F, data writes are dropped and reads return 0x00. Writes to 0x3C1 have no effect.
- R8: A write to 0x3C2 sets misc_out. A read of 0x3C2 returns status 0, which is 0x00, and never the misc value.
- R9: After reset, every index, every register and misc_out are 0x00, the attribute toggle is in the index state and video_en is 0.
- R10: A read of any unmapped address returns 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | I/O port address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe; only reads of 0x3DA have a side effect |
| rdata | output | 8 | Read data for the current address (combinational) |
| video_en | output | 1 | Video output enable from attribute index bit 5 |
| misc_out | output | 8 | Miscellaneous output register value |

## Verification
A seeded random mix of accesses spreads over all group ports, the attribute port, the status ports and unmapped addresses. Index values are drawn past each group's size, so in-range storage is exercised alongside silently dropped writes. Attribute writes come interleaved with status-1 reads at random points. A wrong toggle phase then shows up as data landing in the index, or the reverse. Directed cases pin down the reset state, the exact toggle sequence, video enable and blanking, the edge at index 0x15, and the gap between the misc write and the status-0 read at the same address.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int AW       = 10;
  localparam int DW       = 8;
  localparam int NGRP     = 6;
  localparam int ATTR_IW  = 5;
  localparam int VEN_BIT  = 5;

  typedef logic [AW-1:0] port_addr_t;
  typedef logic [DW-1:0] byte_t;

  localparam port_addr_t ATTR_PORT  = 10'h3C0;
  localparam port_addr_t ATTR_RDATA = 10'h3C1;
  localparam port_addr_t MISC_PORT  = 10'h3C2;
  localparam port_addr_t STAT1_PORT = 10'h3DA;

  // group order: sequencer, graphics, CRT, extended, flat panel, multimedia
  function automatic port_addr_t grp_index_addr(input int g);
    case (g)
      0:       return 10'h3C4;
      1:       return 10'h3CE;
      2:       return 10'h3D4;
      3:       return 10'h3D6;
      4:       return 10'h3D0;
      default: return 10'h3D2;
    endcase
  endfunction

  function automatic byte_t attr_index_byte(input logic ven, input logic [ATTR_IW-1:0] idx);
    return {2'b00, ven, idx};
  endfunction
endpackage

// File: rtl/irp_bank.sv
module irp_bank
  import irp_pkg::*;
#(
  parameter int         N        = 8,
  parameter port_addr_t IDX_ADDR = 10'h3C4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  port_addr_t addr,
  input  byte_t      wdata,
  input  logic       wr_en,
  output byte_t      rdata,
  output logic       hit
);
  localparam int         IW       = (N > 1) ? $clog2(N) : 1;
  localparam port_addr_t DAT_ADDR = IDX_ADDR + 1'b1;

  byte_t idx_q;
  byte_t regs [N];
  logic  sel_idx, sel_dat, idx_ok;
  logic  idx_wr, dat_wr;

  assign sel_idx = (addr == IDX_ADDR);
  assign sel_dat = (addr == DAT_ADDR);
  assign hit     = sel_idx | sel_dat;
  assign idx_wr  = wr_en & sel_idx;
  assign dat_wr  = wr_en & sel_dat & idx_ok;

  generate
    if (N >= 256) begin : g_full
      assign idx_ok = 1'b1;
    end else begin : g_part
      localparam byte_t IDX_LIM = byte_t'(N);
      assign idx_ok = (idx_q < IDX_LIM);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (dat_wr) regs[idx_q[IW-1:0]] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_idx)              rdata = idx_q;
    else if (sel_dat && idx_ok) rdata = regs[idx_q[IW-1:0]];
  end

  assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(wdata)));

  assert_data_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> (regs[$past(idx_q[IW-1:0])] == $past(wdata)));

  assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_dat) |=> $stable(idx_q));
endmodule

// File: rtl/irp_attr.sv
module irp_attr
  import irp_pkg::*;
#(
  parameter int N = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  port_addr_t addr,
  input  byte_t      wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output byte_t      rdata,
  output logic       hit,
  output logic       video_en
);
  localparam logic [ATTR_IW-1:0] IDX_LIM = ATTR_IW'(N);

  logic               ff_q;   // 0: next write is an index
  logic [ATTR_IW-1:0] aidx_q;
  logic               ven_q;
  byte_t              areg [N];

  logic sel_port, sel_rd, sel_st1, idx_ok;
  logic idx_wr, dat_wr, ff_clear;

  assign sel_port = (addr == ATTR_PORT);
  assign sel_rd   = (addr == ATTR_RDATA);
  assign sel_st1  = (addr == STAT1_PORT);
  assign hit      = sel_port | sel_rd | sel_st1;
  assign idx_ok   = (aidx_q < IDX_LIM);
  assign ff_clear = rd_en & sel_st1;
  assign idx_wr   = wr_en & sel_port & ~ff_q & ~ff_clear;
  assign dat_wr   = wr_en & sel_port &  ff_q & ~ff_clear;
  assign video_en = ven_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= 1'b0;
      aidx_q <= '0;
      ven_q  <= 1'b0;
      for (int i = 0; i < N; i++) areg[i] <= '0;
    end else begin
      if (ff_clear) ff_q <= 1'b0;
      else if (idx_wr) begin
        ff_q   <= 1'b1;
        aidx_q <= wdata[ATTR_IW-1:0];
        ven_q  <= wdata[VEN_BIT];
      end else if (dat_wr) begin
        ff_q <= 1'b0;
        if (idx_ok) areg[aidx_q] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_port)             rdata = attr_index_byte(ven_q, aidx_q);
    else if (sel_rd && idx_ok) rdata = areg[aidx_q];
  end

  assert_ff_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_port && !ff_clear) |=> (ff_q != $past(ff_q)));

  assert_ff_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clear |=> !ff_q);

  assert_video_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(video_en));

  assert_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> $stable(aidx_q));
endmodule

// File: rtl/irp_regfront.sv
module irp_regfront
  import irp_pkg::*;
#(
  parameter int SEQ_N  = 8,
  parameter int GFX_N  = 9,
  parameter int CRT_N  = 128,
  parameter int EXT_N  = 256,
  parameter int FP_N   = 128,
  parameter int MM_N   = 64,
  parameter int ATTR_N = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       video_en,
  output logic [7:0] misc_out
);
  localparam int GRP_SIZE [NGRP] = '{SEQ_N, GFX_N, CRT_N, EXT_N, FP_N, MM_N};
  localparam int NHIT = NGRP + 2;

  byte_t           bank_rd [NGRP];
  logic [NHIT-1:0] hits;
  byte_t           attr_rd;
  byte_t           misc_q;
  logic            misc_wr;

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_bank
      irp_bank #(
        .N       (GRP_SIZE[g]),
        .IDX_ADDR(grp_index_addr(g))
      ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .wdata(wdata),
        .wr_en(wr_en),
        .rdata(bank_rd[g]),
        .hit  (hits[g])
      );
    end
  endgenerate

  irp_attr #(.N(ATTR_N)) u_attr (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rdata   (attr_rd),
    .hit     (hits[NGRP]),
    .video_en(video_en)
  );

  assign hits[NGRP+1] = (addr == MISC_PORT);
  assign misc_wr      = wr_en & hits[NGRP+1];
  assign misc_out     = misc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       misc_q <= '0;
    else if (misc_wr) misc_q <= wdata;
  end

  // status 0 at the misc address reads as zero
  always_comb begin
    rdata = attr_rd;
    for (int g = 0; g < NGRP; g++) rdata = rdata | bank_rd[g];
  end

  assert_one_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hits));

  assert_misc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !misc_wr |=> $stable(misc_out));
endmodule

// File: tb/irp_regfront_tb.sv
module irp_regfront_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NOPS       = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       video_en;
  logic [7:0] misc_out;

  int checks = 0;
  int errors = 0;

  irp_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .video_en(video_en), .misc_out(misc_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model
  logic [7:0] m_idx [6];
  logic [7:0] m_reg [6][256];
  logic [4:0] m_aidx;
  logic       m_ven, m_ff;
  logic [7:0] m_areg [32];
  logic [7:0] m_misc;

  function automatic logic [9:0] port_of(input int g);
    logic [9:0] t [6] = '{10'h3C4, 10'h3CE, 10'h3D4, 10'h3D6, 10'h3D0, 10'h3D2};
    return t[g];
  endfunction

  function automatic int size_of(input int g);
    int t [6] = '{8, 9, 128, 256, 128, 64};
    return t[g];
  endfunction

  function automatic string req_of(input logic [9:0] a);
    for (int g = 0; g < 6; g++) begin
      if (a == port_of(g))      return "R1";
      if (a == port_of(g) + 1)  return "R2/R3";
    end
    if (a == 10'h3C0) return "R6";
    if (a == 10'h3C1) return "R7";
    if (a == 10'h3C2) return "R8";
    if (a == 10'h3DA) return "R5";
    return "R10";
  endfunction

  task automatic model_reset();
    for (int g = 0; g < 6; g++) begin
      m_idx[g] = 0;
      for (int i = 0; i < 256; i++) m_reg[g][i] = 0;
    end
    for (int i = 0; i < 32; i++) m_areg[i] = 0;
    m_aidx = 0; m_ven = 0; m_ff = 0; m_misc = 0;
  endtask

  task automatic model_write(input logic [9:0] a, input logic [7:0] d);
    for (int g = 0; g < 6; g++) begin
      if (a == port_of(g)) m_idx[g] = d;
      else if (a == port_of(g) + 1 && int'(m_idx[g]) < size_of(g)) m_reg[g][m_idx[g]] = d;
    end
    if (a == 10'h3C0) begin
      if (!m_ff) begin m_aidx = d[4:0]; m_ven = d[5]; m_ff = 1; end
      else begin
        if (m_aidx < 5'd21) m_areg[m_aidx] = d;
        m_ff = 0;
      end
    end
    if (a == 10'h3C2) m_misc = d;
  endtask

  function automatic logic [7:0] model_read(input logic [9:0] a);
    for (int g = 0; g < 6; g++) begin
      if (a == port_of(g)) return m_idx[g];
      if (a == port_of(g) + 1)
        return (int'(m_idx[g]) < size_of(g)) ? m_reg[g][m_idx[g]] : 8'h00;
    end
    if (a == 10'h3C0) return {2'b00, m_ven, m_aidx};
    if (a == 10'h3C1) return (m_aidx < 5'd21) ? m_areg[m_aidx] : 8'h00;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_rd(input logic [9:0] a, input string req);
    logic [7:0] exp;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp = model_read(a);
    #1;
    chk(req, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
    if (a == 10'h3DA) m_ff = 0;
  endtask

  function automatic logic [9:0] pick_addr();
    int k = $urandom_range(0, 19);
    if (k < 12) return (k[0]) ? port_of(k / 2) + 1 : port_of(k / 2);
    case (k)
      12, 13:  return 10'h3C0;
      14:      return 10'h3C1;
      15:      return 10'h3C2;
      16:      return 10'h3DA;
      default: return 10'($urandom_range(0, 1023));
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog got %h exp %h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk("R9 video_en", video_en, 0);
    chk("R9 misc_out", misc_out, 0);
    for (int g = 0; g < 6; g++) do_rd(port_of(g), "R9 index");
    do_rd(10'h3C1, "R9 attr reg");

    // R4/R6 toggle and video enable
    do_wr(10'h3C0, 8'h25);
    chk("R6 video on", video_en, 1);
    do_wr(10'h3C0, 8'hAB);
    do_rd(10'h3C0, "R4 index kept 0x25");
    chk("R4 still on", video_en, 1);
    do_rd(10'h3C1, "R7 attr 5 = AB");
    do_wr(10'h3C0, 8'h03);
    chk("R6 blank", video_en, 0);
    // R5 status read resync: next write is an index
    do_rd(10'h3DA, "R5 status1");
    do_wr(10'h3C0, 8'h34);
    chk("R5 resync index write", video_en, 1);
    do_wr(10'h3C0, 8'h77);            // index 0x14
    do_rd(10'h3C1, "R7 attr 0x14");
    do_rd(10'h3DA, "R5 status1");
    do_wr(10'h3C0, 8'h35);            // index 0x15, out of range
    do_wr(10'h3C0, 8'h99);
    do_rd(10'h3C1, "R7 idx 0x15 reads 0");
    do_wr(10'h3C1, 8'h11);            // read-only address
    do_rd(10'h3C1, "R7 3C1 write ignored");

    // R3 out of range on sequencer
    do_wr(10'h3C4, 8'h07); do_wr(10'h3C5, 8'h5A);
    do_wr(10'h3C4, 8'h08); do_wr(10'h3C5, 8'h55);
    do_rd(10'h3C5, "R3 oor reads 0");
    do_wr(10'h3C4, 8'h07);
    do_rd(10'h3C5, "R3 reg 7 kept");
    // R8 misc
    do_wr(10'h3C2, 8'hE7);
    chk("R8 misc_out", misc_out, 8'hE7);
    do_rd(10'h3C2, "R8 status0");
    // R10 unmapped
    do_wr(10'h3C3, 8'hFF);
    do_rd(10'h3C3, "R10 unmapped");
    chk("R10 misc untouched", misc_out, 8'hE7);

    // random mix
    for (int n = 0; n < NOPS; n++) begin
      logic [9:0] a = pick_addr();
      if ($urandom_range(0, 1)) begin
        logic [7:0] d = 8'($urandom_range(0, 255));
        do_wr(a, d);
        chk("R6 video_en", video_en, m_ven);
        chk("R8 misc_out", misc_out, m_misc);
      end else begin
        do_rd(a, req_of(a));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule